// File: doc/BRIEF.md
# Three-State Transmit Queue Controller

This block is a small transmit queue between a host write port (for example a register interface fed by a serial peripheral bus) and a serial frame engine. The host offers a data word and pulses a push strobe; the frame engine reads the oldest word on `q_dout` and pulses a pop strobe once it has consumed it. The queue holds four words. That count includes the slot being filled by the host and the slot feeding the frame the engine is sending.

Occupancy is not kept as a count. An explicit three-state machine (empty, partly filled, full) owns a write pointer and a read pointer. It moves between states by comparing one pointer with the other minus one. Both strobes take effect on their trailing (falling) edge, which the block finds synchronously by registering each strobe. Dropping the enable input, or raising abort, empties the queue on the next clock and clears both error flags. The asynchronous active-low reset does the same.

Flow control follows stream rules with plain strobes. `q_full` is the host's inverted ready: a push whose strobe falls while full is refused. `q_empty` is the engine's inverted valid: `q_dout` is meaningful only while `q_empty` is low. A refused push or pop does not stall anything. It is dropped and recorded in a sticky error flag.

Top module: `txq_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after a cycle with `en` low or `abort` high, the queue empties: `q_empty`=1, `q_full`=0, `err_ovf`=0, `err_unf`=0.
- R2: A strobe counts only at its trailing edge. This is the first clock edge at which the strobe is sampled low after having been sampled high. Flags do not change while a strobe is held high.
- R3: A pop edge while the queue holds at least one word removes the oldest word. `q_empty` rises when the last word leaves.
- R4: The queue holds exactly four words in first-in first-out order. `q_full`=1 exactly when four words are held, and `q_empty`=1 exactly when none is held.
- R5: A push edge while full is ignored: contents and `q_full` are unchanged, and `err_ovf` is set and stays set until cleared as in R1.
- R6: A pop edge while empty is ignored: `q_empty` stays 1, and `err_unf` is set and stays set until cleared as in R1.
- R7: Push and pop edges in the same cycle with one to three words held remove the oldest word and append the new one, leaving occupancy unchanged. When empty, only the push is taken (and `err_unf` set). When full, only the pop is taken (and `err_ovf` set).
- R8: The word stored by a push is the value of `push_data` in the last cycle the push strobe was sampled high. `q_dout` shows the oldest held word.
- R9: Strobe edges are not counted in any cycle with `en` low or `abort` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; low clears and holds the queue empty |
| abort | input | 1 | Synchronous clear of the queue and error flags |
| push_stb | input | 1 | Host push strobe, acts on falling edge |
| push_data | input | DATA_W | Word offered by the host while the push strobe is high |
| pop_stb | input | 1 | Engine pop strobe, acts on falling edge |
| q_dout | output | DATA_W | Oldest held word, valid while q_empty is 0 |
| q_empty | output | 1 | No word held |
| q_full | output | 1 | Four words held |
| err_ovf | output | 1 | Sticky: a push was refused while full |
| err_unf | output | 1 | Sticky: a pop was refused while empty |

## Verification
The block is driven with isolated pushes and pops that have long high phases, which separates trailing-edge action from leading-edge action. A fill to four followed by a fifth push, and a drain followed by an extra pop, confirm the full and empty boundaries and the sticky errors. Coincident push and pop edges at each occupancy show whether the pointer comparison is taken before or after both pointers move. A long stretch of random strobes, with data changing in every high cycle and with rare aborts and enable drops, exposes wrong word capture, wrong ordering and any missed clear.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    TQ_IDLE = 2'd0,
    TQ_PART = 2'd1,
    TQ_FULL = 2'd2
  } tq_state_e;
endpackage

// File: rtl/txq_fall_det.sv
module txq_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stb,
  output logic fall
);
  logic stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stb_q <= 1'b0;
    else if (clr) stb_q <= 1'b0;
    else          stb_q <= stb;
  end

  assign fall = stb_q & ~stb & ~clr;

  // R2: a trailing edge is a single-cycle event
  a_r2_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_hi,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] held;
  logic [DATA_W-1:0] slot [DEPTH];

  // value offered during the last high cycle of the push strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (push_hi) held <= din;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 slot[g] <= '0;
      else if (wr_en && (wr_ptr == PTR_W'(g)))    slot[g] <= held;
    end
  end

  assign dout = slot[rd_ptr];
endmodule

// File: rtl/txq_fsm.sv
module txq_fsm
  import txq_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push_fall,
  input  logic             pop_fall,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             wr_en,
  output logic             empty,
  output logic             full,
  output logic             ovf,
  output logic             unf
);
  localparam logic [PTR_W-1:0] PONE = PTR_W'(1);

  tq_state_e state, state_nx;
  logic take_push, take_pop;

  assign take_push = push_fall && (state != TQ_FULL);
  assign take_pop  = pop_fall  && (state != TQ_IDLE);
  assign wr_en     = take_push;

  always_comb begin
    state_nx = state;
    case (state)
      TQ_IDLE: if (take_push) state_nx = TQ_PART;
      TQ_PART: begin
        if (take_push && !take_pop && (wr_ptr == rd_ptr - PONE))
          state_nx = TQ_FULL;
        else if (take_pop && !take_push && (rd_ptr == wr_ptr - PONE))
          state_nx = TQ_IDLE;
      end
      TQ_FULL: if (take_pop) state_nx = TQ_PART;
      default: state_nx = TQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= TQ_IDLE;
      wr_ptr <= '0;
      rd_ptr <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else if (clr) begin
      state  <= TQ_IDLE;
      wr_ptr <= '0;
      rd_ptr <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      state <= state_nx;
      if (take_push) wr_ptr <= wr_ptr + PONE;
      if (take_pop)  rd_ptr <= rd_ptr + PONE;
      if (push_fall && state == TQ_FULL) ovf <= 1'b1;
      if (pop_fall  && state == TQ_IDLE) unf <= 1'b1;
    end
  end

  assign empty = (state == TQ_IDLE);
  assign full  = (state == TQ_FULL);

  // R1: a clear empties the queue and drops the errors
  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !full && !ovf && !unf));
  // R4: never from empty straight to full
  a_r4_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> !full);
  // R5: overflow flag is sticky
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
  // R5: refused push leaves write pointer alone
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_fall && !pop_fall && !clr) |=> ($stable(wr_ptr) && full));
  // R6: refused pop leaves read pointer alone
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_fall && !push_fall && !clr) |=> ($stable(rd_ptr) && empty && unf));
  // R7: coincident edges in the partial state keep it partial
  a_r7_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TQ_PART && push_fall && pop_fall && !clr) |=> (state == TQ_PART));
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              abort,
  input  logic              push_stb,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_stb,
  output logic [DATA_W-1:0] q_dout,
  output logic              q_empty,
  output logic              q_full,
  output logic              err_ovf,
  output logic              err_unf
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int NSTB  = 2;

  logic             clr;
  logic [NSTB-1:0]  stb_in, stb_fall;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             wr_en;

  assign clr    = ~en | abort;
  assign stb_in = {pop_stb, push_stb};

  for (genvar s = 0; s < NSTB; s++) begin : g_det
    txq_fall_det u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .stb  (stb_in[s]),
      .fall (stb_fall[s])
    );
  end

  txq_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .push_fall(stb_fall[0]),
    .pop_fall (stb_fall[1]),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .wr_en    (wr_en),
    .empty    (q_empty),
    .full     (q_full),
    .ovf      (err_ovf),
    .unf      (err_unf)
  );

  txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_hi(push_stb),
    .din    (push_data),
    .wr_en  (wr_en),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .dout   (q_dout)
  );

  // R9: no error is raised during a clear
  a_r9_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!err_ovf && !err_unf));
endmodule

// File: tb/tb_txq_ctrl.sv
module tb_txq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, abort = 1'b0, push_stb = 1'b0, pop_stb = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic [7:0] q_dout;
  logic q_empty, q_full, err_ovf, err_unf;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  txq_ctrl #(.DATA_W(8), .DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .abort(abort),
    .push_stb(push_stb), .push_data(push_data), .pop_stb(pop_stb),
    .q_dout(q_dout), .q_empty(q_empty), .q_full(q_full),
    .err_ovf(err_ovf), .err_unf(err_unf)
  );

  // behavioural reference model
  int m_q[$];
  bit m_ovf = 0, m_unf = 0, m_pp = 0, m_pq = 0;
  int m_held = 0;

  always @(posedge clk) begin
    bit pe, qe;
    if (!rst_n || !en || abort) begin
      m_q.delete(); m_ovf = 0; m_unf = 0; m_pp = 0; m_pq = 0;
      if (rst_n && push_stb) m_held = push_data;
      if (!rst_n) m_held = 0;
    end else begin
      pe = m_pp && !push_stb;
      qe = m_pq && !pop_stb;
      if (m_q.size() == 0) begin
        if (qe) m_unf = 1;
        if (pe) m_q.push_back(m_held);
      end else if (m_q.size() == 4) begin
        if (pe) m_ovf = 1;
        if (qe) void'(m_q.pop_front());
      end else begin
        if (qe) void'(m_q.pop_front());
        if (pe) m_q.push_back(m_held);
      end
      if (push_stb) m_held = push_data;
      m_pp = push_stb; m_pq = pop_stb;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(q_empty == (m_q.size() == 0), "R3 empty", q_empty, m_q.size() == 0);
      chk(q_full == (m_q.size() == 4), "R4 full", q_full, m_q.size() == 4);
      chk(err_ovf == m_ovf, "R5 ovf", err_ovf, m_ovf);
      chk(err_unf == m_unf, "R6 unf", err_unf, m_unf);
      if (m_q.size() > 0)
        chk(q_dout == 8'(m_q[0]), "R8 dout", q_dout, m_q[0]);
    end
  end

  // strobe for hi cycles, data changes each high cycle, then release
  task automatic strobe(input bit dp, input bit dq, input logic [7:0] d, input int hi);
    for (int i = 0; i < hi; i++) begin
      push_stb = dp; pop_stb = dq; push_data = d + 8'(i * 17);
      @(negedge clk);
    end
    push_stb = 0; pop_stb = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_abort();
    abort = 1; @(negedge clk); abort = 0; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk(q_empty && !q_full && !err_ovf && !err_unf, "R1 reset state",
        {q_empty, q_full, err_ovf, err_unf}, 4'b1000);
    @(negedge clk); rst_n = 1; en = 1; @(negedge clk);

    // R2: held strobe has no effect until it falls
    push_stb = 1; push_data = 8'h3C;
    repeat (3) @(negedge clk);
    chk(q_empty, "R2 held push", q_empty, 1);
    push_stb = 0; @(negedge clk);
    chk(!q_empty && q_dout == 8'h3C, "R2 fall push", q_dout, 8'h3C);
    strobe(0, 1, 0, 3);
    chk(q_empty, "R3 drained", q_empty, 1);

    // R4/R5 fill and overflow
    for (int k = 0; k < 4; k++) strobe(1, 0, 8'(8'h10 * k + 1), 2);
    chk(q_full, "R4 full after four", q_full, 1);
    strobe(1, 0, 8'hEE, 1);
    chk(err_ovf && q_full, "R5 overflow", err_ovf, 1);
    chk(q_dout == 8'h12, "R8 last-high data", q_dout, 8'h12);

    // R7 coincident edges while full
    strobe(1, 1, 8'h77, 1);
    chk(!q_full && !q_empty, "R7 full both", q_full, 0);

    // drain and R6 underflow
    repeat (3) strobe(0, 1, 0, 1);
    chk(q_empty, "R3 empty after drain", q_empty, 1);
    strobe(0, 1, 0, 1);
    chk(err_unf && q_empty, "R6 underflow", err_unf, 1);
    clear_abort();
    chk(!err_unf && !err_ovf, "R1 abort clears", err_unf, 0);

    // R7 coincident edges at partial occupancy
    strobe(1, 0, 8'hA0, 1);
    strobe(1, 0, 8'hA1, 1);
    strobe(1, 1, 8'hA2, 2);
    chk(q_dout == 8'hA1 && !q_empty && !q_full, "R7 partial both", q_dout, 8'hA1);

    // R9 strobes ignored while disabled
    en = 0; push_stb = 1; pop_stb = 1; @(negedge clk);
    push_stb = 0; pop_stb = 0; @(negedge clk);
    en = 1; @(negedge clk);
    chk(q_empty && !err_unf, "R9 disabled ignore", q_empty, 1);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      push_stb  = ($urandom_range(0, 2) == 0);
      pop_stb   = ($urandom_range(0, 2) == 0);
      push_data = 8'($urandom);
      abort     = ($urandom_range(0, 199) == 0);
      en        = ($urandom_range(0, 249) != 0);
      @(negedge clk);
    end
    push_stb = 0; pop_stb = 0; abort = 0; en = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule